// File: doc/BRIEF.md
# Fetch Loop Buffer

This block sits between the instruction fetch stage and the instruction memory port. It keeps a small window of the instructions most recently brought in from memory, each with its full address. Every fetch request is first compared against all stored addresses at once. When one matches, the block returns the stored word in the same cycle and memory is never asked. When none matches, the block forwards the request to memory. It then waits for the reply, passes the word straight back to the fetch stage and keeps a copy in the oldest slot.

Because the window is the last DEPTH fetches, a tight loop or a short backward jump whose target is still in the window runs with no memory traffic at all once its first pass has gone through. A flush input invalidates the whole window, for example after the code in memory has been changed. The fetch stage presents a request with `fetch_valid` and `fetch_addr` and holds both steady until `fetch_ready` is high. The returned word is valid in that same cycle.

Top module: `fetch_loop_buf`

## Requirements
- R1: After a synchronous reset no entry is valid, so the first fetch of any address, including one that was stored before the reset, goes to memory.
- R2: When `fetch_valid` is high in the lookup state and `fetch_addr` equals a stored address, `fetch_ready` and `fetch_hit` are high in that same cycle, `fetch_instr` carries the stored word, and `mem_req_valid` stays low.
- R3: On a miss, `mem_req_valid` is high in the same cycle with `mem_req_addr` equal to `fetch_addr`, and `fetch_ready` is low. Both stay unchanged until the cycle in which `mem_req_ready` is high.
- R4: While a memory request is outstanding, the cycle with `mem_rsp_valid` high has `fetch_ready` high, `fetch_hit` low and `fetch_instr` equal to `mem_rsp_data`. A later fetch of that address then hits.
- R5: Only one memory request is outstanding at a time. `mem_req_valid` stays low from the accepting handshake until the response cycle has passed.
- R6: Filled words go into slots in round-robin order 0, 1, …, DEPTH-1, 0, … Once all slots hold valid words, a new miss evicts the entry that was filled earliest.
- R7: A `flush` pulse invalidates every entry from the next cycle on. A response that arrives in the same cycle as `flush` is still delivered to the fetch stage but is not stored, and the fill slot does not advance.
- R8: A loop of at most DEPTH distinct instruction addresses runs its second and later passes entirely from the buffer, with no memory request.
- R9: While `fetch_valid` is low and no request is outstanding, `fetch_ready`, `fetch_hit` and `mem_req_valid` are all low.
- R10: A flush raised after a memory request was accepted but before its response does not drop that fill. The word that arrives later is stored and hits on the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | ADDR_W | Instruction address, held until accepted |
| fetch_ready | output | 1 | Request completed; word valid this cycle |
| fetch_instr | output | DATA_W | Returned instruction word |
| fetch_hit | output | 1 | Word was served from the buffer |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_rsp_valid | input | 1 | Memory returns the word |
| mem_rsp_data | input | DATA_W | Word read from memory |

## Verification
The hardest state to reach from the ports is a flush that collides with an in-flight fill. In one case the flush lands in the very response cycle, so the word must be delivered but not kept. In the other it lands between the handshake and the response, so the word must be kept. The bench acts as the memory itself and controls when it accepts and when it answers. That lets it place the flush pulse on an exact negative edge relative to both events. It then probes the same address again to see whether it hits or misses. Eviction order is reached by a fixed sequence that fills every slot and then mixes hits among misses, so that the wrapping fill pointer has to pass over entries that are still in use.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [0:0] {
    LB_LOOKUP = 1'b0,
    LB_WAIT   = 1'b1
  } lb_state_e;
endpackage

// File: rtl/lb_tag_array.sv
module lb_tag_array #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_tag,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [DEPTH-1:0]  match_vec,
  output logic [DEPTH-1:0]  valid_vec,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [ADDR_W-1:0] tag_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        valid_vec[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_vec[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        tag_q[g] <= wr_tag;
      end
    end

    assign match_vec[g] = valid_vec[g] && (tag_q[g] == lk_addr);
  end

  assign hit = |match_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) begin
        hit_idx = hit_idx | IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lb_data_ram.sv
module lb_data_ram #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fetch_valid,
  input  logic             lookup_hit,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  output logic             fetch_ready,
  output logic             fetch_hit,
  output logic             mem_req_valid,
  output logic             capture,
  output logic             fill_en,
  output logic [IDX_W-1:0] fill_idx
);
  lb_state_e        state_q, state_d;
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    state_d       = state_q;
    fetch_ready   = 1'b0;
    fetch_hit     = 1'b0;
    mem_req_valid = 1'b0;
    capture       = 1'b0;
    fill_en       = 1'b0;
    unique case (state_q)
      LB_LOOKUP: begin
        if (fetch_valid) begin
          if (lookup_hit) begin
            fetch_ready = 1'b1;
            fetch_hit   = 1'b1;
          end else begin
            mem_req_valid = 1'b1;
            if (mem_req_ready) begin
              capture = 1'b1;
              state_d = LB_WAIT;
            end
          end
        end
      end
      LB_WAIT: begin
        if (mem_rsp_valid) begin
          fetch_ready = 1'b1;
          fill_en     = !flush;
          state_d     = LB_LOOKUP;
        end
      end
      default: state_d = LB_LOOKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LB_LOOKUP;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fill_en) begin
        ptr_q <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  assign fill_idx = ptr_q;
endmodule

// File: rtl/fetch_loop_buf.sv
module fetch_loop_buf #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_instr,
  output logic              fetch_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  match_vec;
  logic [DEPTH-1:0]  entry_valid;
  logic              lookup_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              capture;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;
  logic [ADDR_W-1:0] pend_tag_q;
  logic [DATA_W-1:0] ram_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_tag_q <= '0;
    end else if (capture) begin
      pend_tag_q <= fetch_addr;
    end
  end

  lb_tag_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .clear     (flush),
    .wr_en     (fill_en),
    .wr_idx    (fill_idx),
    .wr_tag    (pend_tag_q),
    .lk_addr   (fetch_addr),
    .match_vec (match_vec),
    .valid_vec (entry_valid),
    .hit       (lookup_hit),
    .hit_idx   (hit_idx)
  );

  lb_data_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_words (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_idx  (fill_idx),
    .wr_data (mem_rsp_data),
    .rd_idx  (hit_idx),
    .rd_data (ram_word)
  );

  lb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .fetch_valid   (fetch_valid),
    .lookup_hit    (lookup_hit),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .fetch_ready   (fetch_ready),
    .fetch_hit     (fetch_hit),
    .mem_req_valid (mem_req_valid),
    .capture       (capture),
    .fill_en       (fill_en),
    .fill_idx      (fill_idx)
  );

  assign mem_req_addr = fetch_addr;
  assign fetch_instr  = fetch_hit ? ram_word : mem_rsp_data;
endmodule

// File: rtl/fetch_loop_buf_chk.sv
module fetch_loop_buf_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              fetch_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [DEPTH-1:0]  entry_valid,
  input logic [DEPTH-1:0]  match_vec
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      outstanding <= 1'b1;
    end else if (mem_rsp_valid) begin
      outstanding <= 1'b0;
    end
  end

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    fetch_hit |-> (fetch_ready && !mem_req_valid)); // R2

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(match_vec) <= 1); // R2

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3

  AST_MISS_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !fetch_ready); // R3

  AST_FILL_FROM_MEM: assert property (@(posedge clk) disable iff (rst)
    (fetch_ready && !fetch_hit) |-> (outstanding && mem_rsp_valid)); // R4

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !mem_req_valid); // R5

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (entry_valid == '0)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !outstanding) |-> (!fetch_ready && !mem_req_valid)); // R9
endmodule

bind fetch_loop_buf fetch_loop_buf_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .flush         (flush),
  .fetch_valid   (fetch_valid),
  .fetch_ready   (fetch_ready),
  .fetch_hit     (fetch_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .entry_valid   (entry_valid),
  .match_vec     (match_vec)
);

// File: tb/fetch_loop_buf_tb.sv
module fetch_loop_buf_tb;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NVEC   = 24;

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
  } vec_t;

  // DEPTH = 8; rows 13..23 exercise round-robin eviction
  localparam vec_t VECS [NVEC] = '{
    '{32'h100, 1'b0}, '{32'h104, 1'b0}, '{32'h108, 1'b0}, '{32'h10C, 1'b0},
    '{32'h100, 1'b1}, '{32'h104, 1'b1}, '{32'h108, 1'b1}, '{32'h10C, 1'b1},
    '{32'h104, 1'b1}, '{32'h200, 1'b0}, '{32'h204, 1'b0}, '{32'h208, 1'b0},
    '{32'h20C, 1'b0}, '{32'h100, 1'b1}, '{32'h300, 1'b0}, '{32'h100, 1'b0},
    '{32'h104, 1'b0}, '{32'h10C, 1'b1}, '{32'h300, 1'b1}, '{32'h20C, 1'b1},
    '{32'h108, 1'b0}, '{32'h10C, 1'b0}, '{32'h204, 1'b1}, '{32'h200, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              flush = 1'b0;
  logic              fetch_valid = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic              fetch_ready;
  logic [DATA_W-1:0] fetch_instr;
  logic              fetch_hit;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fetch_loop_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .fetch_valid   (fetch_valid),
    .fetch_addr    (fetch_addr),
    .fetch_ready   (fetch_ready),
    .fetch_instr   (fetch_instr),
    .fetch_hit     (fetch_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, ~a[15:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // fl: 0 none, 1 flush while waiting for the response, 2 flush in the response cycle
  task automatic do_fetch(input logic [31:0] a, input logic exp_hit, input string req,
                          input int stall, input int lat, input int fl);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    #1;
    chk(req, "hit flag", 32'(fetch_hit), 32'(exp_hit));
    if (fetch_ready) begin
      chk(req, "hit word", fetch_instr, word_of(a));
      chk(req, "no mem req on hit", 32'(mem_req_valid), 32'd0);
      @(posedge clk);
    end else begin
      chk("R3", "mem req", 32'(mem_req_valid), 32'd1);
      chk("R3", "mem addr", mem_req_addr, a);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        #1;
        chk("R3", "req held", 32'(mem_req_valid), 32'd1);
        chk("R3", "not ready", 32'(fetch_ready), 32'd0);
      end
      mem_req_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_req_ready = 1'b0;
      #1;
      chk("R5", "no second req", 32'(mem_req_valid), 32'd0);
      if (fl == 1) begin
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end
      for (int l = 0; l < lat; l++) @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = word_of(a);
      flush         = (fl == 2);
      #1;
      chk("R4", "fill ready", 32'(fetch_ready), 32'd1);
      chk("R4", "fill not hit", 32'(fetch_hit), 32'd0);
      chk("R4", "fill word", fetch_instr, word_of(a));
      @(posedge clk);
    end
    @(negedge clk);
    fetch_valid   = 1'b0;
    mem_rsp_valid = 1'b0;
    flush         = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "reset ready", 32'(fetch_ready), 32'd0);
    chk("R1", "reset mem req", 32'(mem_req_valid), 32'd0);

    // Table: misses fill, loop replays hit (R8), then eviction in round-robin order (R6)
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      if (i >= 4 && i <= 8)  tag = "R8";
      else if (i >= 13)      tag = "R6";
      else if (VECS[i].hit)  tag = "R2";
      else                   tag = (i == 0) ? "R1" : "R4";
      do_fetch(VECS[i].addr, VECS[i].hit, tag, i % 3, i % 2, 0);
    end

    // R9: idle request line keeps outputs low
    @(negedge clk);
    #1;
    chk("R9", "idle ready", 32'(fetch_ready), 32'd0);
    chk("R9", "idle mem req", 32'(mem_req_valid), 32'd0);
    chk("R9", "idle hit", 32'(fetch_hit), 32'd0);

    // R7: flush invalidates everything
    do_fetch(32'h20C, 1'b1, "R7", 0, 0, 0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    do_fetch(32'h20C, 1'b0, "R7", 0, 0, 0);
    do_fetch(32'h20C, 1'b1, "R7", 0, 0, 0);

    // R7: flush in the response cycle drops the fill
    do_fetch(32'h600, 1'b0, "R7", 1, 1, 2);
    do_fetch(32'h600, 1'b0, "R7", 0, 0, 0);
    do_fetch(32'h600, 1'b1, "R7", 0, 0, 0);

    // R10: flush between handshake and response keeps the fill
    do_fetch(32'h700, 1'b0, "R10", 0, 2, 1);
    do_fetch(32'h700, 1'b1, "R10", 0, 0, 0);
    do_fetch(32'h20C, 1'b0, "R10", 0, 0, 0);

    // R1: reset clears previously stored addresses
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", "post reset ready", 32'(fetch_ready), 32'd0);
    do_fetch(32'h700, 1'b0, "R1", 0, 0, 0);
    do_fetch(32'h700, 1'b1, "R2", 0, 0, 0);

    finish_run();
  end
endmodule